// File: doc/BRIEF.md
# Split-write buffer threshold configurator

This block builds three 12-bit buffer settings from a narrow 16-bit write port: the circular buffer length, the output-buffer almost-empty threshold and the output-buffer almost-full threshold. Software hands the settings over as four 16-bit words in a fixed order. Each word carries an 8-bit low part or a 4-bit high part of one or two settings, at fixed bit positions.

A setting write only stages its word. The word is accepted when an access to a separate dummy update address follows it. Each accepted word advances a step counter. When the fourth step is accepted, all three settings move to the outputs in the same cycle and a done flag rises. Writes and updates are honoured only while the programming-mode input is high. Reset brings back the power-on state.

Top module: `buf_thr_cfg`

## Requirements
- R1: After reset, all three setting outputs are 0, `step_o` is 0 and `done_o` is 0.
- R2: The word accepted at step 0 supplies almost-empty threshold bits [7:0] from data bits [15:8]. Its other data bits are ignored.
- R3: The word accepted at step 1 supplies almost-empty threshold bits [11:8] from data bits [11:8]. Its other data bits are ignored.
- R4: The word accepted at step 2 supplies almost-full threshold bits [7:0] from data bits [15:8] and circular length bits [7:0] from data bits [7:0].
- R5: The word accepted at step 3 supplies almost-full threshold bits [11:8] from data bits [11:8] and circular length bits [11:8] from data bits [3:0]. Data bits [15:12] and [7:4] are ignored.
- R6: When several setting writes come before one update, only the last one is used. The earlier ones are lost.
- R7: `step_o` advances by one only on an update that has a staged write. An update with no staged write changes nothing.
- R8: All three outputs change together, and only one cycle after step 3 is accepted. In that same cycle `done_o` becomes 1 and `step_o` returns to 0.
- R9: While `prog_mode_i` is 0, setting writes and updates have no effect on `step_o`, on the outputs or on any staged word.
- R10: A partly completed sequence leaves the committed outputs unchanged. `done_o` falls when step 0 of a new sequence is accepted, so `done_o` high always implies `step_o` equal to 0.
- R11: Asserting reset in the middle of a sequence returns the block to its R1 state.
- R12: Both thresholds and the length accept every value from 0 to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_mode_i | input | 1 | 1 while the module is in programming mode |
| set_wr_i | input | 1 | Write strobe for the setting register |
| set_data_i | input | 16 | Setting word |
| upd_i | input | 1 | Access strobe for the dummy update address |
| ae_thr_o | output | 12 | Committed almost-empty threshold |
| af_thr_o | output | 12 | Committed almost-full threshold |
| cbl_o | output | 12 | Committed circular buffer length |
| step_o | output | 2 | Index of the next step to be accepted |
| done_o | output | 1 | A full sequence has been committed |

## Verification
The bench uses the default parameters: a 16-bit word, 12-bit values split into an 8-bit low part and a 4-bit high part, and four steps. With these values every field position in R2 to R5 can be seen at the ports. Unused data bits are driven with non-zero filler, so any leakage from those bits reaches an output. The extreme values 0 and 4095, and a sequence repeated after done, exercise the full field widths and the wrap of the step counter.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;
  parameter int unsigned DATA_W   = 16;
  parameter int unsigned VAL_W    = 12;
  parameter int unsigned LO_W     = 8;
  parameter int unsigned STEPS    = 4;
  parameter int unsigned NUM_VALS = 3;

  // value index: 0 almost-empty, 1 almost-full, 2 circular length
  function automatic int unsigned lo_step(int unsigned v);
    return (v == 0) ? 0 : 2;
  endfunction

  function automatic int unsigned hi_step(int unsigned v);
    return (v == 0) ? 1 : 3;
  endfunction

  function automatic int unsigned lo_off(int unsigned v);
    return (v == 2) ? 0 : 8;
  endfunction

  function automatic int unsigned hi_off(int unsigned v);
    return (v == 2) ? 0 : 8;
  endfunction
endpackage

// File: rtl/fcfg_stage.sv
module fcfg_stage #(
  parameter int unsigned DATA_W = fcfg_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] word_o,
  output logic              pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      pend_o <= 1'b0;
    end else if (en_i) begin
      if (wr_i) begin
        word_o <= data_i;  // later write replaces an unconfirmed one
        pend_o <= 1'b1;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
    end
  end

  assert_stage_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_o) && $stable(pend_o));

  assert_last_write_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && wr_i |=> pend_o && word_o == $past(data_i));
endmodule

// File: rtl/fcfg_seq.sv
module fcfg_seq #(
  parameter int unsigned STEPS = fcfg_pkg::STEPS,
  localparam int unsigned SW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [SW-1:0] step_o,
  output logic          last_o
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  assign last_o = (step_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_o <= '0;
    else if (adv_i)  step_o <= last_o ? '0 : step_o + 1'b1;
  end

  assert_step_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(step_o));

  assert_step_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && last_o |=> step_o == '0);
endmodule

// File: rtl/fcfg_bank.sv
module fcfg_bank #(
  parameter int unsigned DATA_W   = fcfg_pkg::DATA_W,
  parameter int unsigned VAL_W    = fcfg_pkg::VAL_W,
  parameter int unsigned LO_W     = fcfg_pkg::LO_W,
  parameter int unsigned STEPS    = fcfg_pkg::STEPS,
  parameter int unsigned NUM_VALS = fcfg_pkg::NUM_VALS,
  localparam int unsigned SW      = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int unsigned HI_W    = VAL_W - LO_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cap_i,
  input  logic                              commit_i,
  input  logic [SW-1:0]                     step_i,
  input  logic [DATA_W-1:0]                 word_i,
  output logic [NUM_VALS-1:0][VAL_W-1:0]    vals_o,
  output logic                              done_o
);
  for (genvar g = 0; g < NUM_VALS; g++) begin : g_val
    localparam int unsigned LO_OFF = fcfg_pkg::lo_off(g);
    localparam int unsigned HI_OFF = fcfg_pkg::hi_off(g);
    localparam logic [SW-1:0] LO_ST = SW'(fcfg_pkg::lo_step(g));
    localparam logic [SW-1:0] HI_ST = SW'(fcfg_pkg::hi_step(g));

    logic [LO_W-1:0] lo_q, lo_d;
    logic [HI_W-1:0] hi_q, hi_d;

    always_comb begin
      lo_d = (cap_i && step_i == LO_ST) ? word_i[LO_OFF +: LO_W] : lo_q;
      hi_d = (cap_i && step_i == HI_ST) ? word_i[HI_OFF +: HI_W] : hi_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q      <= '0;
        hi_q      <= '0;
        vals_o[g] <= '0;
      end else begin
        lo_q <= lo_d;
        hi_q <= hi_d;
        if (commit_i) vals_o[g] <= {hi_d, lo_d};  // shadow plus final part
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        done_o <= 1'b0;
    else if (commit_i)                  done_o <= 1'b1;
    else if (cap_i && step_i == '0)     done_o <= 1'b0;
  end

  assert_out_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(vals_o));

  assert_done_on_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> done_o);
endmodule

// File: rtl/buf_thr_cfg.sv
module buf_thr_cfg #(
  parameter int unsigned DATA_W = fcfg_pkg::DATA_W,
  parameter int unsigned VAL_W  = fcfg_pkg::VAL_W,
  parameter int unsigned LO_W   = fcfg_pkg::LO_W,
  parameter int unsigned STEPS  = fcfg_pkg::STEPS,
  localparam int unsigned SW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_mode_i,
  input  logic              set_wr_i,
  input  logic [DATA_W-1:0] set_data_i,
  input  logic              upd_i,
  output logic [VAL_W-1:0]  ae_thr_o,
  output logic [VAL_W-1:0]  af_thr_o,
  output logic [VAL_W-1:0]  cbl_o,
  output logic [SW-1:0]     step_o,
  output logic              done_o
);
  localparam int unsigned NV = fcfg_pkg::NUM_VALS;

  logic [DATA_W-1:0]        word;
  logic                     pend, acc, last;
  logic [NV-1:0][VAL_W-1:0] vals;

  assign acc = prog_mode_i && upd_i && pend;

  fcfg_stage #(.DATA_W(DATA_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (prog_mode_i),
    .wr_i   (set_wr_i),
    .data_i (set_data_i),
    .take_i (acc),
    .word_o (word),
    .pend_o (pend)
  );

  fcfg_seq #(.STEPS(STEPS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (acc),
    .step_o (step_o),
    .last_o (last)
  );

  fcfg_bank #(
    .DATA_W(DATA_W), .VAL_W(VAL_W), .LO_W(LO_W), .STEPS(STEPS), .NUM_VALS(NV)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (acc),
    .commit_i (acc && last),
    .step_i   (step_o),
    .word_i   (word),
    .vals_o   (vals),
    .done_o   (done_o)
  );

  assign ae_thr_o = vals[0];
  assign af_thr_o = vals[1];
  assign cbl_o    = vals[2];

  assert_done_at_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> step_o == '0);

  assert_idle_outside_prog_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_mode_i |=> $stable(step_o) && $stable(done_o) && $stable(cbl_o));
endmodule

// File: tb/buf_thr_cfg_test.sv
module buf_thr_cfg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog = 1'b1;
  logic        wr = 1'b0;
  logic [15:0] data = '0;
  logic        upd = 1'b0;
  logic [11:0] ae, af, cbl;
  logic [1:0]  step;
  logic        done;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  buf_thr_cfg uut (
    .clk_i(clk), .rst_ni(rst_n), .prog_mode_i(prog), .set_wr_i(wr),
    .set_data_i(data), .upd_i(upd), .ae_thr_o(ae), .af_thr_o(af),
    .cbl_o(cbl), .step_o(step), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] d);
    @(negedge clk); wr = 1'b1; data = d;
    @(negedge clk); wr = 1'b0; data = 16'hDEAD;
  endtask

  task automatic do_upd();
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic program_all(input logic [11:0] e, input logic [11:0] f, input logic [11:0] c);
    do_wr({e[7:0], 8'hA5});                 do_upd();
    do_wr({4'hF, e[11:8], 8'h3C});          do_upd();
    do_wr({f[7:0], c[7:0]});                do_upd();
    do_wr({4'h9, f[11:8], 4'h6, c[11:8]});  do_upd();
  endtask

  task automatic t_reset();
    chk("R1 ae", ae, 0); chk("R1 af", af, 0); chk("R1 cbl", cbl, 0);
    chk("R1 step", step, 0); chk("R1 done", done, 0);
  endtask

  task automatic t_fields();
    program_all(12'h4B7, 12'h91E, 12'hC28);
    chk("R2 ae lo", ae[7:0], 8'hB7);
    chk("R3 ae hi", ae[11:8], 4'h4);
    chk("R4 af lo", af[7:0], 8'h1E);
    chk("R4 cbl lo", cbl[7:0], 8'h28);
    chk("R5 af hi", af[11:8], 4'h9);
    chk("R5 cbl hi", cbl[11:8], 4'hC);
    chk("R8 done", done, 1); chk("R8 step wrap", step, 0);
  endtask

  task automatic t_partial();
    do_wr(16'h1100); do_upd();
    chk("R10 done falls", done, 0); chk("R7 step 1", step, 1);
    do_wr(16'h0700); do_upd();
    do_wr(16'h2233); do_upd();
    chk("R10 ae held", ae, 12'h4B7); chk("R10 af held", af, 12'h91E);
    chk("R10 cbl held", cbl, 12'hC28); chk("R7 step 3", step, 3);
    do_wr(16'h0204); do_upd();
    chk("R8 ae new", ae, 12'h711); chk("R8 af new", af, 12'h222);
    chk("R8 cbl new", cbl, 12'h433);
  endtask

  task automatic t_overwrite();
    do_wr(16'h5500); do_wr(16'h6600); do_upd();
    do_wr(16'h0100); do_wr(16'h0300); do_upd();
    do_wr(16'h0000); do_upd();
    do_wr(16'h0000); do_upd();
    chk("R6 last write used", ae, 12'h366);
  endtask

  task automatic t_no_update();
    do_upd();
    chk("R7 bare update", step, 0);
    do_wr(16'h7700);
    chk("R7 write alone", step, 0);
    do_upd(); do_upd();
    chk("R7 one advance", step, 1);
  endtask

  task automatic t_mode();
    prog = 1'b0;
    do_wr(16'hFFFF); do_upd(); do_upd();
    chk("R9 step frozen", step, 1);
    prog = 1'b1;
    do_upd();
    chk("R9 nothing staged", step, 1);
  endtask

  task automatic t_mid_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 step", step, 0); chk("R11 ae", ae, 0);
    chk("R11 cbl", cbl, 0); chk("R11 done", done, 0);
  endtask

  task automatic t_extremes();
    program_all(12'hFFF, 12'h000, 12'hFFF);
    chk("R12 ae max", ae, 12'hFFF); chk("R12 af min", af, 0);
    chk("R12 cbl max", cbl, 12'hFFF);
    program_all(12'h000, 12'hFFF, 12'h000);
    chk("R12 ae min", ae, 0); chk("R12 af max", af, 12'hFFF);
    chk("R12 cbl min", cbl, 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_partial();
    t_overwrite();
    t_no_update();
    t_mode();
    t_mid_reset();
    t_extremes();
    finish_up();
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end
endmodule